// File: doc/BRIEF.md
# Storage Port Interrupt Status Logic

This block keeps the interrupt status and interrupt enable registers of one serial storage host port and drives the port's interrupt request. The frame receive engine reports each frame that has been copied to memory as a one-cycle pulse, together with a frame type code and the frame's interrupt flag. A separate pulse reports that the data phase of a PIO transfer has finished. Five error-condition pulses, a global interrupt enable and a strobe that clears the unknown-frame diagnostic flag are also inputs.

Software reaches the two registers through a single-cycle register port. A read is combinational on the address. A write to the status register clears every write-one-to-clear bit that has a 1 in the write data. A write to the enable register loads its writable bits. The unknown-frame status bit cannot be cleared by software through this port. It sets only when an unknown frame has been posted to memory, and it clears only when the diagnostic flag that tracks it is cleared. That flag lives outside this block, and its clear arrives here as a strobe.

Top module: `stor_port_irq`

## Requirements
- R1: After reset the status register and the enable register read 0x00000000, and irq_o is 0.
- R2: A post pulse with type code 0 (device-to-host register frame) and the interrupt flag set sets status bit 0. The same frame without the flag leaves the status unchanged.
- R3: Status bit 1 sets only when two events have both happened: a post with type code 1 (PIO setup) and the flag set, then the data-done pulse, which may come in the same cycle as the post or later. A post alone does not set bit 1, and a data-done pulse without such a post does not set it either.
- R4: A flagged post with type code 2 (DMA setup) sets status bit 2. A flagged post with type code 3 (set device bits) sets status bit 3.
- R5: A post with type code 4 (unknown frame) sets status bit 4 whatever the interrupt flag is. Bit 4 stays 0 until that post arrives, a software write of 1 to it has no effect, and it clears only on the diagnostic-clear strobe.
- R6: Status bits 0 to 3 and the error bits are write-one-to-clear. Writing 0 to any of them leaves it unchanged.
- R7: When a hardware set and a clear reach the same status bit in the same cycle, the bit ends up set. The clear can be a software write-one or the diagnostic strobe.
- R8: Error input bits 0 to 4 set status bits 24 (overflow), 26 (interface non-fatal), 27 (host bus data), 29 (host bus fatal) and 30 (task file error), in that order.
- R9: The writable enable bits are 0 to 4, 24, 26, 27, 29 and 30. All other enable and status positions read 0 and ignore writes, so the status register reads 0x6D00001F at most. An unmapped address reads 0 and ignores writes.
- R10: Status bits keep updating while their enable bits are 0.
- R11: In the cycle after any status bit and its enable bit are both 1 while gie_i is 1, irq_o is 1. Otherwise it is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_post_i | input | 1 | A received frame has been copied to memory |
| frm_type_i | input | 3 | Type of the posted frame: 0 D2H, 1 PIO, 2 DMA, 3 SDB, 4 unknown |
| frm_iflag_i | input | 1 | Interrupt flag carried by the posted frame |
| pio_done_i | input | 1 | PIO data phase finished |
| err_set_i | input | 5 | Error condition pulses, mapped as listed in R8 |
| diag_unk_clr_i | input | 1 | The unknown-frame diagnostic flag was cleared |
| gie_i | input | 1 | Global interrupt enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Port interrupt request (registered) |

## Verification
The bench builds the block with ADDR_W=3, the status register at address 2 and the enable register at address 5. With that map, address 0 is unmapped and shows that decoding does not fall back to either register, and neither register sits at offset zero. The same build reaches the deferred PIO completion, the unknown bit held low before posting and then cleared only by the diagnostic strobe, and both forms of a set colliding with a clear.

// File: rtl/stor_irq_pkg.sv
package stor_irq_pkg;

  localparam int unsigned REG_W   = 32;
  localparam int unsigned NUM_ERR = 5;

  typedef enum logic [2:0] {
    FRM_D2H = 3'd0,
    FRM_PIO = 3'd1,
    FRM_DMA = 3'd2,
    FRM_SDB = 3'd3,
    FRM_UNK = 3'd4
  } frm_type_e;

  localparam int unsigned BIT_D2H = 0;
  localparam int unsigned BIT_PIO = 1;
  localparam int unsigned BIT_DMA = 2;
  localparam int unsigned BIT_SDB = 3;
  localparam int unsigned BIT_UNK = 4;

  // overflow, iface non-fatal, hb data, hb fatal, task file
  localparam int unsigned ERR_POS [NUM_ERR] = '{24, 26, 27, 29, 30};

  function automatic logic [REG_W-1:0] calc_err_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_ERR; i++) m[ERR_POS[i]] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] ERR_MASK  = calc_err_mask();
  localparam logic [REG_W-1:0] FRM_MASK  = REG_W'(32'h0000_001F);
  localparam logic [REG_W-1:0] IMPL_MASK = ERR_MASK | FRM_MASK;
  localparam logic [REG_W-1:0] W1C_MASK  = IMPL_MASK & ~(REG_W'(1) << BIT_UNK);
  localparam logic [REG_W-1:0] ENA_MASK  = IMPL_MASK;

endpackage

// File: rtl/stor_irq_status.sv
module stor_irq_status
  import stor_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frm_post_i,
  input  logic [2:0]         frm_type_i,
  input  logic               frm_iflag_i,
  input  logic               pio_done_i,
  input  logic [NUM_ERR-1:0] err_set_i,
  input  logic               diag_unk_clr_i,
  input  logic [REG_W-1:0]   w1c_i,
  output logic [REG_W-1:0]   sts_o
);

  logic [REG_W-1:0] sts_q, sts_d, set_v, clr_v;
  logic             pio_pend_q, pio_pend_d;
  logic             pio_post;
  logic             pio_hit;

  assign pio_post = frm_post_i && frm_iflag_i && (frm_type_i == FRM_PIO);
  assign pio_hit  = pio_done_i && (pio_pend_q || pio_post);

  always_comb begin
    pio_pend_d = pio_pend_q;
    if (pio_hit)       pio_pend_d = 1'b0;
    else if (pio_post) pio_pend_d = 1'b1;
  end

  always_comb begin
    set_v          = '0;
    set_v[BIT_D2H] = frm_post_i && frm_iflag_i && (frm_type_i == FRM_D2H);
    set_v[BIT_PIO] = pio_hit;
    set_v[BIT_DMA] = frm_post_i && frm_iflag_i && (frm_type_i == FRM_DMA);
    set_v[BIT_SDB] = frm_post_i && frm_iflag_i && (frm_type_i == FRM_SDB);
    set_v[BIT_UNK] = frm_post_i && (frm_type_i == FRM_UNK);
    for (int i = 0; i < NUM_ERR; i++) set_v[ERR_POS[i]] = err_set_i[i];
  end

  always_comb begin
    clr_v          = w1c_i & W1C_MASK;
    clr_v[BIT_UNK] = diag_unk_clr_i;
  end

  // set wins over clear
  assign sts_d = ((sts_q & ~clr_v) | set_v) & IMPL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q      <= '0;
      pio_pend_q <= 1'b0;
    end else begin
      sts_q      <= sts_d;
      pio_pend_q <= pio_pend_d;
    end
  end

  assign sts_o = sts_q;

endmodule

// File: rtl/stor_irq_enable.sv
module stor_irq_enable
  import stor_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ena_o
);

  logic [REG_W-1:0] ena_q;

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (ENA_MASK[g]) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ena_q[g] <= 1'b0;
        else if (we_i) ena_q[g] <= wdata_i[g];
      end
    end else begin : g_zero
      assign ena_q[g] = 1'b0;
    end
  end

  assign ena_o = ena_q;

endmodule

// File: rtl/stor_irq_combine.sv
module stor_irq_combine
  import stor_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic [REG_W-1:0] sts_i,
  input  logic [REG_W-1:0] ena_i,
  output logic             irq_o
);

  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= gie_i && (|(sts_i & ena_i));
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/stor_port_irq.sv
module stor_port_irq
  import stor_irq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned STS_OFF = 0,
  parameter int unsigned ENA_OFF = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frm_post_i,
  input  logic [2:0]         frm_type_i,
  input  logic               frm_iflag_i,
  input  logic               pio_done_i,
  input  logic [NUM_ERR-1:0] err_set_i,
  input  logic               diag_unk_clr_i,
  input  logic               gie_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  output logic               irq_o
);

  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFF);
  localparam logic [ADDR_W-1:0] ENA_A = ADDR_W'(ENA_OFF);

  logic             sel_sts, sel_ena;
  logic [REG_W-1:0] sts_q, ena_q, w1c;

  assign sel_sts = (reg_addr_i == STS_A);
  assign sel_ena = (reg_addr_i == ENA_A);
  assign w1c     = (reg_we_i && sel_sts) ? reg_wdata_i : '0;

  stor_irq_status i_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frm_post_i     (frm_post_i),
    .frm_type_i     (frm_type_i),
    .frm_iflag_i    (frm_iflag_i),
    .pio_done_i     (pio_done_i),
    .err_set_i      (err_set_i),
    .diag_unk_clr_i (diag_unk_clr_i),
    .w1c_i          (w1c),
    .sts_o          (sts_q)
  );

  stor_irq_enable i_enable (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i && sel_ena),
    .wdata_i (reg_wdata_i),
    .ena_o   (ena_q)
  );

  stor_irq_combine i_combine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gie_i  (gie_i),
    .sts_i  (sts_q),
    .ena_i  (ena_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel_sts)      reg_rdata_o = sts_q;
    else if (sel_ena) reg_rdata_o = ena_q;
  end

endmodule

// File: rtl/stor_port_irq_chk.sv
module stor_port_irq_chk
  import stor_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frm_post_i,
  input logic [2:0]         frm_type_i,
  input logic               frm_iflag_i,
  input logic               pio_done_i,
  input logic [NUM_ERR-1:0] err_set_i,
  input logic               diag_unk_clr_i,
  input logic               gie_i,
  input logic [REG_W-1:0]   sts_q,
  input logic [REG_W-1:0]   ena_q,
  input logic               irq_o
);

  a_r2_d2h_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_post_i && frm_iflag_i && frm_type_i == FRM_D2H) |=> sts_q[BIT_D2H]);

  a_r3_pio_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[BIT_PIO]) |-> $past(pio_done_i));

  a_r5_unk_only_on_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[BIT_UNK]) |-> $past(frm_post_i && frm_type_i == FRM_UNK));

  a_r5_unk_clear_by_diag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_q[BIT_UNK]) |-> $past(diag_unk_clr_i));

  a_r8_overflow_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i[0] |=> sts_q[ERR_POS[0]]);

  a_r9_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q | ena_q) & ~IMPL_MASK) == '0);

  a_r11_irq_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(gie_i));

  a_r11_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gie_i && |(sts_q & ena_q)) |=> irq_o);

endmodule

bind stor_port_irq stor_port_irq_chk i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .frm_post_i     (frm_post_i),
  .frm_type_i     (frm_type_i),
  .frm_iflag_i    (frm_iflag_i),
  .pio_done_i     (pio_done_i),
  .err_set_i      (err_set_i),
  .diag_unk_clr_i (diag_unk_clr_i),
  .gie_i          (gie_i),
  .sts_q          (sts_q),
  .ena_q          (ena_q),
  .irq_o          (irq_o)
);

// File: tb/test_stor_port_irq.sv
module test_stor_port_irq;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 3;
  localparam int A_STS      = 2;
  localparam int A_ENA      = 5;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frm_post_i = 1'b0;
  logic [2:0]  frm_type_i = '0;
  logic        frm_iflag_i = 1'b0;
  logic        pio_done_i = 1'b0;
  logic [4:0]  err_set_i = '0;
  logic        diag_unk_clr_i = 1'b0;
  logic        gie_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stor_port_irq #(.ADDR_W(ADDR_W), .STS_OFF(A_STS), .ENA_OFF(A_ENA)) i_stor_port_irq (
    .clk_i, .rst_ni, .frm_post_i, .frm_type_i, .frm_iflag_i, .pio_done_i,
    .err_set_i, .diag_unk_clr_i, .gie_i, .reg_addr_i, .reg_we_i,
    .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      #(CLK_PERIOD/4);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {31'd0, irq_o} : reg_rdata_o;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %08h expected %08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input int a, input logic [31:0] e, input string r);
    item_t it;
    reg_addr_i = ADDR_W'(a);
    it.is_irq = 1'b0; it.exp = e; it.req = r;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic chk_irq(input logic e, input string r);
    item_t it;
    @(negedge clk_i);
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.req = r;
    q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic post(input logic [2:0] t, input logic f);
    frm_post_i = 1'b1; frm_type_i = t; frm_iflag_i = f;
    @(negedge clk_i);
    frm_post_i = 1'b0; frm_iflag_i = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr_i = ADDR_W'(a); reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1
    chk_reg(A_STS, 32'h0, "R1 status reset");
    chk_reg(A_ENA, 32'h0, "R1 enable reset");
    chk_irq(1'b0, "R1 irq reset");

    // R2, R10
    post(3'd0, 1'b0);
    chk_reg(A_STS, 32'h0, "R2 d2h without flag");
    post(3'd0, 1'b1);
    chk_reg(A_STS, 32'h1, "R2 d2h with flag, R10 enable off");
    chk_irq(1'b0, "R11 no irq while disabled");

    // R6
    wr(A_STS, 32'h0);
    chk_reg(A_STS, 32'h1, "R6 write zero keeps bit");
    wr(A_STS, 32'h1);
    chk_reg(A_STS, 32'h0, "R6 w1c bit0");

    // R3
    post(3'd1, 1'b1);
    chk_reg(A_STS, 32'h0, "R3 pio post alone");
    pio_done_i = 1'b1; @(negedge clk_i); pio_done_i = 1'b0;
    chk_reg(A_STS, 32'h2, "R3 pio after data done");
    wr(A_STS, 32'h2);
    pio_done_i = 1'b1; @(negedge clk_i); pio_done_i = 1'b0;
    chk_reg(A_STS, 32'h0, "R3 data done without post");
    frm_post_i = 1'b1; frm_type_i = 3'd1; frm_iflag_i = 1'b1; pio_done_i = 1'b1;
    @(negedge clk_i);
    frm_post_i = 1'b0; frm_iflag_i = 1'b0; pio_done_i = 1'b0;
    chk_reg(A_STS, 32'h2, "R3 pio post and done together");
    wr(A_STS, 32'h2);

    // R4
    post(3'd2, 1'b1);
    chk_reg(A_STS, 32'h4, "R4 dma setup");
    post(3'd3, 1'b1);
    chk_reg(A_STS, 32'hC, "R4 set device bits");
    wr(A_STS, 32'hC);
    chk_reg(A_STS, 32'h0, "R6 w1c bits 2 3");

    // R5
    frm_type_i = 3'd4;
    @(negedge clk_i);
    chk_reg(A_STS, 32'h0, "R5 unknown before posting");
    post(3'd4, 1'b0);
    chk_reg(A_STS, 32'h10, "R5 unknown posted");
    wr(A_STS, 32'h10);
    chk_reg(A_STS, 32'h10, "R5 write one ignored");
    diag_unk_clr_i = 1'b1; @(negedge clk_i); diag_unk_clr_i = 1'b0;
    chk_reg(A_STS, 32'h0, "R5 diag clear");

    // R8
    err_set_i = 5'b10101; @(negedge clk_i); err_set_i = '0;
    chk_reg(A_STS, 32'h4900_0000, "R8 errors 0 2 4");
    err_set_i = 5'b01010; @(negedge clk_i); err_set_i = '0;
    chk_reg(A_STS, 32'h6D00_0000, "R8 all errors");
    wr(A_STS, 32'hFFFF_FFFF);
    chk_reg(A_STS, 32'h0, "R6 w1c errors");

    // R9
    wr(A_ENA, 32'hFFFF_FFFF);
    chk_reg(A_ENA, 32'h6D00_001F, "R9 enable mask");
    chk_reg(0, 32'h0, "R9 unmapped read");
    wr(0, 32'hFFFF_FFFF);
    chk_reg(A_ENA, 32'h6D00_001F, "R9 unmapped write ignored");
    chk_reg(A_STS, 32'h0, "R9 status untouched");

    // R11
    wr(A_ENA, 32'h4);
    gie_i = 1'b1;
    post(3'd3, 1'b1);
    chk_irq(1'b0, "R11 disabled source");
    post(3'd2, 1'b1);
    chk_irq(1'b1, "R11 enabled source");
    gie_i = 1'b0;
    chk_irq(1'b0, "R11 global off");
    gie_i = 1'b1;
    chk_irq(1'b1, "R11 global on");
    wr(A_STS, 32'h4);
    chk_irq(1'b0, "R11 after clear");
    wr(A_STS, 32'h8);

    // R7
    frm_post_i = 1'b1; frm_type_i = 3'd0; frm_iflag_i = 1'b1;
    reg_addr_i = ADDR_W'(A_STS); reg_we_i = 1'b1; reg_wdata_i = 32'h1;
    @(negedge clk_i);
    frm_post_i = 1'b0; frm_iflag_i = 1'b0; reg_we_i = 1'b0; reg_wdata_i = '0;
    chk_reg(A_STS, 32'h1, "R7 set beats w1c");
    post(3'd4, 1'b1);
    frm_post_i = 1'b1; frm_type_i = 3'd4; diag_unk_clr_i = 1'b1;
    @(negedge clk_i);
    frm_post_i = 1'b0; diag_unk_clr_i = 1'b0;
    chk_reg(A_STS, 32'h11, "R7 set beats diag clear");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule